// File: doc/BRIEF.md
# Pipelined Converter Code Combiner

This block sits behind the analog core of a 10-bit pipelined converter. The core has eight redundant 1.5-bit stages and a 2-bit backend flash. Every clock, each stage and the flash present a 2-bit decision code. A stage finishes a given sample later than the stage before it. The block delays each stage's code so that all codes of one sample arrive together. It then adds them with a one-bit overlap between neighbours and registers the result as one binary word per clock.

The overlap lets a later stage absorb an offset error in an earlier stage's comparators. A 1.5-bit stage can only produce three codes. If the fourth code arrives, the block treats it as the highest legal code and raises a sticky error flag.

Top module: `adc_code_combiner`

## Requirements
- R1: A synchronous, active-high `rst` sampled at a clock edge sets `dout` to zero, `dout_valid` low and `code_err` low after that edge.
- R2: The stage code at bit field `stage_codes[2k-1:2k-2]` (k = 1 is the first stage) counts with weight 2^(N+1-k), where N = 8. The flash code counts with weight 1. Legal stage codes are 00, 01 and 10, read as 0, 1 and 2. `dout` is the full sum of these weighted codes, with carries rippling through every bit.
- R3: The codes of one sample arrive in a fixed pattern. Stage k sees its code k-1 cycles after stage 1, and the flash sees its code N cycles after stage 1. `dout` for that sample appears right after the clock edge at which the flash code was taken in.
- R4: Bit 0 of a valid `dout` equals bit 0 of the flash code taken in at the previous edge.
- R5: After reset is released, `dout_valid` stays low for the first N clock edges and is high after every later edge.
- R6: A stage code of 11 is added as if it were 10.
- R7: Any stage input equal to 11 at a clock edge outside reset sets `code_err` after that edge. The flag stays set until reset.
- R8: Every stage at 10 with a flash code of 11 gives 1023, the largest possible value. The result fits in 10 bits without wrapping.
- R9: A flash code of 11 is legal. It adds 3 and never sets `code_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| stage_codes | input | 16 | Raw 2-bit codes; stage k in bits [2k-1:2k-2] |
| flash_code | input | 2 | Backend flash code, 0 to 3 |
| dout | output | 10 | Corrected binary word |
| dout_valid | output | 1 | High once the delay lines hold real samples |
| code_err | output | 1 | Sticky flag: an illegal stage code was seen |

## Verification
Two things can happen in the same clock edge. An illegal 11 can enter one stage while that same stage's earlier, substituted code is being summed into the word of an older sample. The bench places 11 codes in the skewed input stream, so the error flag rises at the edge it is predicted to rise. In that same cycle, the output word must still match the arithmetic sum with 11 read as 2. Both results are compared against values computed in the bench at every cycle, and a reset issued afterwards must clear the set flag.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    localparam int CODE_W = 2;
    typedef logic [CODE_W-1:0] code_t;
    localparam code_t CODE_TOP = 2'b10;
    localparam code_t CODE_ILLEGAL = 2'b11;
endpackage

// File: rtl/pdc_code_screen.sv
module pdc_code_screen #(
    parameter int N_STAGES = 8
) (
    input  logic [2*N_STAGES-1:0] raw_codes,
    output logic [2*N_STAGES-1:0] clean_codes,
    output logic                  any_illegal
);
    import pdc_pkg::*;

    logic [N_STAGES-1:0] illegal_hit;

    for (genvar g = 0; g < N_STAGES; g++) begin : g_screen
        always_comb begin
            illegal_hit[g] = (raw_codes[2*g +: 2] == CODE_ILLEGAL);
            clean_codes[2*g +: 2] = illegal_hit[g] ? CODE_TOP : raw_codes[2*g +: 2];
        end
    end

    assign any_illegal = |illegal_hit;
endmodule

// File: rtl/pdc_align_delay.sv
module pdc_align_delay #(
    parameter int W     = 2,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    if (DEPTH == 0) begin : g_bypass
        assign dout = din;
    end else begin : g_taps
        typedef struct packed {
            logic [DEPTH-1:0][W-1:0] taps;
        } line_t;

        line_t line_d, line_q;

        always_comb begin
            line_d.taps[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                line_d.taps[i] = line_q.taps[i-1];
            end
            if (rst) begin
                line_d = '0;
            end
        end

        always_ff @(posedge clk) begin
            line_q <= line_d;
        end

        assign dout = line_q.taps[DEPTH-1];
    end
endmodule

// File: rtl/pdc_overlap_sum.sv
module pdc_overlap_sum #(
    parameter int N_STAGES = 8
) (
    input  logic [2*N_STAGES-1:0] aligned_codes,
    input  logic [1:0]            flash_code,
    output logic [N_STAGES+1:0]   total
);
    localparam int ACC_W = N_STAGES + 2;

    always_comb begin
        total = ACC_W'(flash_code);
        for (int i = 0; i < N_STAGES; i++) begin
            total = total + (ACC_W'(aligned_codes[2*i +: 2]) << (N_STAGES - i));
        end
    end
endmodule

// File: rtl/adc_code_combiner.sv
module adc_code_combiner #(
    parameter int N_STAGES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2*N_STAGES-1:0] stage_codes,
    input  logic [1:0]            flash_code,
    output logic [N_STAGES+1:0]   dout,
    output logic                  dout_valid,
    output logic                  code_err
);
    localparam int OUT_W  = N_STAGES + 2;
    localparam int FILL_W = $clog2(N_STAGES + 1);

    typedef struct packed {
        logic [OUT_W-1:0]  word;
        logic              valid;
        logic              err;
        logic [FILL_W-1:0] fill;
    } state_t;

    state_t st_d, st_q;

    logic [2*N_STAGES-1:0] screened;
    logic [2*N_STAGES-1:0] aligned;
    logic                  illegal_now;
    logic [OUT_W-1:0]      sum_w;

    pdc_code_screen #(.N_STAGES(N_STAGES)) screen_i (
        .raw_codes   (stage_codes),
        .clean_codes (screened),
        .any_illegal (illegal_now)
    );

    // Stage k (index k-1) finishes a sample k-1 cycles after stage 1, and the
    // flash finishes it N cycles after stage 1. So index i is delayed by N - i.
    for (genvar g = 0; g < N_STAGES; g++) begin : g_align
        pdc_align_delay #(.W(2), .DEPTH(N_STAGES - g)) dly_i (
            .clk  (clk),
            .rst  (rst),
            .din  (screened[2*g +: 2]),
            .dout (aligned[2*g +: 2])
        );
    end

    pdc_overlap_sum #(.N_STAGES(N_STAGES)) sum_i (
        .aligned_codes (aligned),
        .flash_code    (flash_code),
        .total         (sum_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.word  = sum_w;
        st_d.valid = (st_q.fill == FILL_W'(N_STAGES));
        st_d.err   = st_q.err | illegal_now;
        if (st_q.fill != FILL_W'(N_STAGES)) begin
            st_d.fill = st_q.fill + 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout       = st_q.word;
    assign dout_valid = st_q.valid;
    assign code_err   = st_q.err;
endmodule

// File: rtl/adc_code_combiner_chk.sv
module adc_code_combiner_chk #(
    parameter int N_STAGES = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [2*N_STAGES-1:0] stage_codes,
    input logic [1:0]            flash_code,
    input logic [N_STAGES+1:0]   dout,
    input logic                  dout_valid,
    input logic                  code_err
);
    localparam int CNT_W = $clog2(N_STAGES + 2);

    logic [CNT_W-1:0] edges_q;
    logic             bad_in;

    always_comb begin
        bad_in = 1'b0;
        for (int i = 0; i < N_STAGES; i++) begin
            if (stage_codes[2*i +: 2] == 2'b11) bad_in = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) edges_q <= '0;
        else if (edges_q <= CNT_W'(N_STAGES)) edges_q <= edges_q + 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!dout_valid && !code_err && dout == '0)); // R1
    AST_FILL_VALID: assert property (@(posedge clk) disable iff (rst)
        dout_valid == (edges_q > CNT_W'(N_STAGES))); // R5
    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        bad_in |=> code_err); // R7
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        code_err |=> code_err); // R7
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!code_err && !bad_in) |=> !code_err); // R9
    AST_FLASH_LSB: assert property (@(posedge clk) disable iff (rst)
        (edges_q >= CNT_W'(N_STAGES)) |=> (dout[0] == $past(flash_code[0]))); // R4
endmodule

bind adc_code_combiner adc_code_combiner_chk #(.N_STAGES(N_STAGES)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .stage_codes (stage_codes),
    .flash_code  (flash_code),
    .dout        (dout),
    .dout_valid  (dout_valid),
    .code_err    (code_err)
);

// File: tb/adc_code_combiner_tb_top.sv
module adc_code_combiner_tb_top;
    localparam int N  = 8;
    localparam int NS = 300;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2*N-1:0]  stage_codes = '0;
    logic [1:0]      flash_code = '0;
    logic [N+1:0]    dout;
    logic            dout_valid;
    logic            code_err;

    int checks = 0;
    int errors = 0;
    int stg [NS][N];
    int fl  [NS];
    bit has_bad [NS];
    int unsigned lfsr = 32'h1ACE_B00C;

    always #4 clk = ~clk;

    adc_code_combiner #(.N_STAGES(N)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .stage_codes (stage_codes),
        .flash_code  (flash_code),
        .dout        (dout),
        .dout_valid  (dout_valid),
        .code_err    (code_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int unsigned next_rand();
        lfsr ^= lfsr << 13;
        lfsr ^= lfsr >> 17;
        lfsr ^= lfsr << 5;
        return lfsr;
    endfunction

    function automatic int expect_word(int m);
        int s = fl[m];
        for (int k = 0; k < N; k++) begin
            s += ((stg[m][k] == 3) ? 2 : stg[m][k]) * (1 << (N - k));
        end
        return s;
    endfunction

    task automatic build(input bit allow_bad);
        for (int m = 0; m < NS; m++) begin
            has_bad[m] = 1'b0;
            fl[m] = int'(next_rand() % 4);
            for (int k = 0; k < N; k++) begin
                stg[m][k] = int'(next_rand() % 3);
                if (allow_bad && m > 40 && (next_rand() % 16) == 0) stg[m][k] = 3;
                if (stg[m][k] == 3) has_bad[m] = 1'b1;
            end
        end
        for (int k = 0; k < N; k++) begin
            stg[0][k] = 2;
            stg[1][k] = 0;
        end
        fl[0] = 3;
        fl[1] = 0;
        has_bad[0] = 1'b0;
        has_bad[1] = 1'b0;
        // walking single-stage patterns
        for (int m = 2; m < 2 + 3 * N; m++) begin
            for (int k = 0; k < N; k++) stg[m][k] = 0;
            stg[m][(m - 2) / 3] = (m - 2) % 3;
            fl[m] = m % 4;
            has_bad[m] = 1'b0;
        end
    endtask

    task automatic check_reset_state();
        chk(dout == '0, "R1 dout", int'(dout), 0);
        chk(!dout_valid, "R1 valid", int'(dout_valid), 0);
        chk(!code_err, "R1 err", int'(code_err), 0);
    endtask

    task automatic run_phase();
        bit exp_err = 1'b0;
        bit drove_bad;
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        for (int c = 0; c < NS + N; c++) begin
            drove_bad = 1'b0;
            for (int k = 0; k < N; k++) begin
                int idx = c - k;
                int v = (idx >= 0 && idx < NS) ? stg[idx][k] : 0;
                stage_codes[2*k +: 2] = 2'(v);
                if (v == 3) drove_bad = 1'b1;
            end
            flash_code = (c >= N) ? 2'(fl[c - N]) : 2'b00;
            @(posedge clk);
            if (drove_bad) exp_err = 1'b1;
            @(negedge clk);
            chk(dout_valid == (c >= N), "R5 valid fill", int'(dout_valid), int'(c >= N));
            chk(code_err == exp_err, "R7 R9 error flag", int'(code_err), int'(exp_err));
            if (c >= N) begin
                int m = c - N;
                int e = expect_word(m);
                if (m == 0)
                    chk(int'(dout) == e && e == 1023, "R8 full scale", int'(dout), 1023);
                else if (has_bad[m])
                    chk(int'(dout) == e, "R6 substituted code", int'(dout), e);
                else
                    chk(int'(dout) == e, "R2 R3 aligned sum", int'(dout), e);
                chk(dout[0] == fl[m][0], "R4 flash lsb", int'(dout[0]), fl[m] & 1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        build(1'b0);
        run_phase();
        build(1'b1);
        run_phase();
        chk(code_err, "R7 sticky at end", int'(code_err), 1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_state();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule